// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block is a write-only serial configuration port for a frequency synthesizer. A host drives three lines: a data line, a serial clock and an active-low enable. While the enable is low, each rising edge of the serial clock shifts one data bit into a 21-bit frame register. Clock edges that arrive while the enable is high are ignored. A burst may be any length. Only the most recent 21 bits are kept, and the bits are not counted.

When the enable returns high, the frame is split into two parts. The first 17 bits shifted in form the data field. The final 4 bits form the address. A single load pulse then writes the data field into the latch that the address selects. There are three functional latches: the main divider ratio, the reference divider ratio and a control word. A fourth address is reserved for a test register, and writes to it have no effect. Writes to any other address are dropped.

All three serial lines are resynchronized to the system clock. Each line passes through a two-stage synchronizer, and edges are detected in the system clock domain. The port keeps accepting writes whether or not the software power-on bit is set, so a powered-down synthesizer can still be reprogrammed.

Top module: `ser3_prog_port`

## Requirements
- R1: Serial clock rising edges that occur while the enable is high shift nothing and change no output. Bits are captured only while the enable is low.
- R2: After a burst of any length, the frame holds the last 21 bits received. Earlier leading bits are discarded.
- R3: The first bit of a 21-bit frame is data bit 16 and the last bit is address bit 0. The address is sent MSB first.
- R4: Address 4'b0100 loads the 17-bit main ratio from data bits 16..0. The first data bit sent is the MSB.
- R5: Address 4'b0001 loads the 11-bit reference ratio from data bits 10..0. Data bits 16..11 are ignored.
- R6: Address 4'b0101 loads the control word from data bits 3..0. Bit 3 is current select bit 1, bit 2 is current select bit 0, bit 1 is the software power-on bit and bit 0 is the lock-detector enable (1 = enabled). Data bits 16..4 are ignored.
- R7: Outputs change only in response to a rising edge of the enable, and one such edge writes at most one latch. Shifting a burst while the enable is still low leaves all outputs unchanged.
- R8: A write to the test address 4'b0000, including a nonzero data value, or to any of the twelve unused addresses leaves every output unchanged.
- R9: After reset, both ratios, the current select bits, the software power-on bit and the lock-detector enable are all 0.
- R10: Ratio writes take effect while the software power-on bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data, sent MSB first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge loads a latch |
| main_ratio | output | 17 | Latched main divider ratio |
| ref_ratio | output | 11 | Latched reference divider ratio |
| cp_sel | output | 2 | Charge-pump current select {bit1, bit0} |
| sw_pon | output | 1 | Software power-on bit |
| lock_en | output | 1 | Lock-detector enable |

## Verification
Some rules are checked by the assertions on every cycle:
- Idle clocking must leave the frame register untouched.
- At most one latch strobe fires per enable edge, and any strobe coincides with that edge.
- The outputs hold steady between loads.
- A write to an unused or test address changes nothing.
- Each functional latch takes its value from the frame that was present at the load.

Other behaviour is visible only through the bench's scenarios:
- how a long burst, or a short burst that follows clock edges with the enable high, combines with the bits already in the frame;
- where each field sits within the data word;
- that reprogramming still works after the power-on bit is cleared.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  localparam int FRAME_W = 21;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = FRAME_W - ADDR_W;
  localparam int MAIN_W  = 17;
  localparam int REF_W   = 11;
  localparam int CPSEL_W = 2;

  localparam logic [ADDR_W-1:0] ADR_TEST = 4'b0000;
  localparam logic [ADDR_W-1:0] ADR_MAIN = 4'b0100;
  localparam logic [ADDR_W-1:0] ADR_REF  = 4'b0001;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'b0101;

  typedef struct packed {
    logic [CPSEL_W-1:0] cp_sel;
    logic               sw_pon;
    logic               lock_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Trailing bits of the frame are the address.
  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  // Leading bits of the frame are the data field.
  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic logic [MAIN_W-1:0] data_to_main(input logic [DATA_W-1:0] d);
    return d[MAIN_W-1:0];
  endfunction

  function automatic logic [REF_W-1:0] data_to_ref(input logic [DATA_W-1:0] d);
    return d[REF_W-1:0];
  endfunction

  function automatic ctrl_t data_to_ctrl(input logic [DATA_W-1:0] d);
    return ctrl_t'(d[CTRL_W-1:0]);
  endfunction
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] sync_prev
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
      else        chain <= {chain[STAGES-1:0], async_in[g]};
    end
    assign sync_out[g]  = chain[STAGES-1];
    assign sync_prev[g] = chain[STAGES];
  end
endmodule

// File: rtl/ser3_shift.sv
module ser3_shift
  import ser3_pkg::*;
#(
  parameter int W = FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[W-2:0], bit_in};
  end
endmodule

// File: rtl/ser3_decode.sv
module ser3_decode
  import ser3_pkg::*;
(
  input  logic               load,
  input  logic [ADDR_W-1:0]  addr,
  output logic               wr_main,
  output logic               wr_ref,
  output logic               wr_ctrl
);
  always_comb begin
    wr_main = 1'b0;
    wr_ref  = 1'b0;
    wr_ctrl = 1'b0;
    if (load) begin
      unique case (addr)
        ADR_MAIN: wr_main = 1'b1;
        ADR_REF:  wr_ref  = 1'b1;
        ADR_CTRL: wr_ctrl = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ser3_regs.sv
module ser3_regs
  import ser3_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_main,
  input  logic               wr_ref,
  input  logic               wr_ctrl,
  input  logic [DATA_W-1:0]  data,
  output logic [MAIN_W-1:0]  main_q,
  output logic [REF_W-1:0]   ref_q,
  output ctrl_t              ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      ref_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_main) main_q <= data_to_main(data);
      if (wr_ref)  ref_q  <= data_to_ref(data);
      if (wr_ctrl) ctrl_q <= data_to_ctrl(data);
    end
  end
endmodule

// File: rtl/ser3_prog_port.sv
module ser3_prog_port
  import ser3_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_en_n,
  output logic [MAIN_W-1:0]  main_ratio,
  output logic [REF_W-1:0]   ref_ratio,
  output logic [CPSEL_W-1:0] cp_sel,
  output logic               sw_pon,
  output logic               lock_en
);
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_EN  = 2;

  logic [2:0] line_s, line_d;
  logic       en_low, shift_pulse, load_pulse;
  logic [FRAME_W-1:0] frame;
  logic wr_main, wr_ref, wr_ctrl;
  ctrl_t ctrl_q;

  ser3_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_en_n, ser_data, ser_clk}),
    .sync_out(line_s), .sync_prev(line_d)
  );

  assign en_low      = ~line_s[IDX_EN];
  assign shift_pulse = en_low & line_s[IDX_CLK] & ~line_d[IDX_CLK];
  assign load_pulse  = line_s[IDX_EN] & ~line_d[IDX_EN];

  ser3_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_pulse),
    .bit_in(line_s[IDX_DAT]), .frame(frame)
  );

  ser3_decode u_dec (
    .load(load_pulse), .addr(frame_addr(frame)),
    .wr_main(wr_main), .wr_ref(wr_ref), .wr_ctrl(wr_ctrl)
  );

  ser3_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_main(wr_main), .wr_ref(wr_ref), .wr_ctrl(wr_ctrl),
    .data(frame_data(frame)),
    .main_q(main_ratio), .ref_q(ref_ratio), .ctrl_q(ctrl_q)
  );

  assign cp_sel  = ctrl_q.cp_sel;
  assign sw_pon  = ctrl_q.sw_pon;
  assign lock_en = ctrl_q.lock_en;
endmodule

// File: rtl/ser3_prog_port_chk.sv
module ser3_prog_port_chk
  import ser3_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en_low,
  input logic               load_pulse,
  input logic [FRAME_W-1:0] frame,
  input logic               wr_main,
  input logic               wr_ref,
  input logic               wr_ctrl,
  input logic [MAIN_W-1:0]  main_ratio,
  input logic [REF_W-1:0]   ref_ratio,
  input logic [CPSEL_W-1:0] cp_sel,
  input logic               sw_pon,
  input logic               lock_en
);
  logic [ADDR_W-1:0] a;
  assign a = frame[ADDR_W-1:0];

  AST_IDLE_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low |=> $stable(frame)); // R1

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_main, wr_ref, wr_ctrl})); // R7

  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_main || wr_ref || wr_ctrl) |-> load_pulse); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> ($stable(main_ratio) && $stable(ref_ratio) && $stable(cp_sel)
                     && $stable(sw_pon) && $stable(lock_en))); // R7

  AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && a != ADR_MAIN && a != ADR_REF && a != ADR_CTRL)
      |=> ($stable(main_ratio) && $stable(ref_ratio) && $stable(cp_sel)
           && $stable(sw_pon) && $stable(lock_en))); // R8

  AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && a == ADR_MAIN) |=> main_ratio == $past(frame[FRAME_W-1:ADDR_W])); // R4

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && a == ADR_REF) |=> ref_ratio == $past(frame[ADDR_W+REF_W-1:ADDR_W])); // R5

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && a == ADR_CTRL)
      |=> {cp_sel, sw_pon, lock_en} == $past(frame[ADDR_W+3:ADDR_W])); // R6
endmodule

bind ser3_prog_port ser3_prog_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_low(en_low), .load_pulse(load_pulse),
  .frame(frame), .wr_main(wr_main), .wr_ref(wr_ref), .wr_ctrl(wr_ctrl),
  .main_ratio(main_ratio), .ref_ratio(ref_ratio), .cp_sel(cp_sel),
  .sw_pon(sw_pon), .lock_en(lock_en)
);

// File: tb/test_ser3_prog_port.sv
module test_ser3_prog_port;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_en_n = 1;
  logic [16:0] main_ratio;
  logic [10:0] ref_ratio;
  logic [1:0]  cp_sel;
  logic        sw_pon, lock_en;
  int n_chk = 0, n_bad = 0;
  logic [20:0] sr_model = '0;
  bit done = 0;

  always #2 clk = ~clk;

  ser3_prog_port i_ser3_prog_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en_n(ser_en_n), .main_ratio(main_ratio), .ref_ratio(ref_ratio),
    .cp_sel(cp_sel), .sw_pon(sw_pon), .lock_en(lock_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    ser_data = b;
    wait_cyc(3);
    ser_clk = 1;
    if (!ser_en_n) sr_model = {sr_model[19:0], b};
    wait_cyc(3);
    ser_clk = 0;
  endtask

  // Burst of n bits, first sent is bits[n-1]; enable is left low.
  task automatic shift_bits(input logic [63:0] bits, input int n);
    ser_en_n = 0;
    wait_cyc(3);
    for (int i = n - 1; i >= 0; i--) pulse_bit(bits[i]);
    wait_cyc(3);
  endtask

  task automatic close_frame();
    ser_en_n = 1;
    wait_cyc(10);
  endtask

  task automatic write(input logic [16:0] d, input logic [3:0] a);
    shift_bits({43'd0, d, a}, 21);
    close_frame();
  endtask

  task automatic chk_all(input string req, input logic [16:0] m, input logic [10:0] r,
                         input logic [3:0] c);
    chk(req, main_ratio, m);
    chk(req, ref_ratio, r);
    chk(req, {cp_sel, sw_pon, lock_en}, c);
  endtask

  task automatic t_reset();
    chk_all("R9 reset", 17'd0, 11'd0, 4'd0);
  endtask

  task automatic t_main();
    write(17'h1ABCD, 4'b0100);
    chk("R4 main", main_ratio, 17'h1ABCD);
    write(17'h1FFFF, 4'b0100);
    chk("R3 main all ones", main_ratio, 17'h1FFFF);
    write(17'h10000, 4'b0100);
    chk("R3 first bit is MSB", main_ratio, 17'h10000);
  endtask

  task automatic t_ref();
    write({6'b101011, 11'h2A5}, 4'b0001);
    chk("R5 ref", ref_ratio, 11'h2A5);
    chk("R5 main untouched", main_ratio, 17'h10000);
  endtask

  task automatic t_ctrl();
    write({13'h1FFF, 4'b1011}, 4'b0101);
    chk("R6 ctrl", {cp_sel, sw_pon, lock_en}, 4'b1011);
    write({13'h0, 4'b0100}, 4'b0101);
    chk("R6 ctrl2", {cp_sel, sw_pon, lock_en}, 4'b0100);
  endtask

  task automatic t_long();
    shift_bits({34'd0, 9'h1FF, 17'h0F0F1, 4'b0100}, 30);
    close_frame();
    chk("R2 long burst", main_ratio, 17'h0F0F1);
  endtask

  task automatic t_idle_and_hold();
    logic [20:0] exp;
    write(17'h12345, 4'b0100);
    ser_en_n = 1;
    for (int i = 0; i < 7; i++) pulse_bit(1'b1);
    wait_cyc(5);
    chk("R1 idle clocks no output change", main_ratio, 17'h12345);
    shift_bits({48'd0, 12'hABC, 4'b0100}, 16);
    chk("R7 no change before enable rise", main_ratio, 17'h12345);
    exp = sr_model;
    close_frame();
    chk("R1 idle clocks not shifted", main_ratio, exp[20:4]);
  endtask

  task automatic t_unused();
    logic [16:0] m = main_ratio;
    logic [10:0] r = ref_ratio;
    logic [3:0]  c = {cp_sel, sw_pon, lock_en};
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 1 && a != 5) write(17'h1FFFF, 4'(a));
    end
    chk_all("R8 unused and test addresses", m, r, c);
  endtask

  task automatic t_powerdown();
    write(17'h0, 4'b0101);
    chk("R10 powered down", sw_pon, 1'b0);
    write(17'h00777, 4'b0100);
    chk("R10 main while down", main_ratio, 17'h00777);
    write(17'h00123, 4'b0001);
    chk("R10 ref while down", ref_ratio, 11'h123);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(4);
    t_reset();
    t_main();
    t_ref();
    t_ctrl();
    t_long();
    t_idle_and_hold();
    t_unused();
    t_powerdown();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule